// File: doc/BRIEF.md
# Page write load controller

This block sits behind a byte-wide asynchronous memory bus and turns single byte writes into page programming operations. The chip-enable, write-enable and output-enable strobes are brought into the system clock domain. Each strobe must hold a level for a minimum number of clocks before the controller acts on it, so short glitches are rejected. A write pulse loads one byte into a page buffer. The address is taken when the pulse starts and the data when it ends.

A load timer is restarted by every byte and held while a write pulse is in progress. When the timer runs out, the page closes and a programming phase of fixed length begins, and `busy_n` is driven low for that phase. When the phase ends, the loaded bytes are copied into a register array, provided every byte named the same page. If any byte named a different page, the whole page is thrown away.

Reads work as on a static RAM. While the controller is busy, a read returns the array's previous contents. The load timeout, the programming length and the glitch threshold are parameters counted in clock cycles. The page field is the address above the low `BYTE_W` bits.

Top module: `pwl_ctrl_top`

## Requirements
- R1: A bus write is recognised only while chip enable and write enable are both low and output enable is high. Any other combination of strobes loads nothing.
- R2: The byte address is taken in the cycle the recognised write condition begins. The data byte is taken in the cycle it ends. Later address changes and earlier data values have no effect.
- R3: Bytes written to one page are committed together in a single programming phase, provided each one ends no more than `LOAD_CYC` clocks after the previous one.
- R4: `LOAD_CYC` clocks after the last byte is taken, with no write pulse in progress, `busy_n` falls.
- R5: If any loaded byte carries page bits (address bits `ADDR_W-1` down to `BYTE_W`) that differ from the first byte's, no location of the array changes. The programming phase still runs.
- R6: `busy_n` stays low for exactly `WC_CYC` clocks. It then returns high and stays high until another page is loaded.
- R7: After reset, every array location reads FFh and `busy_n` is high.
- R8: A write pulse that begins while `busy_n` is low is ignored. It changes no location and starts no further programming phase.
- R9: Locations in the committed page that were not loaded keep their previous values.
- R10: A strobe level held for fewer than `FILT_CYC` clocks is filtered out and cannot start a write.
- R11: While chip enable and output enable are low and write enable is high, `dout` shows the addressed array byte and `dout_vld` is high. During the programming phase the byte shown is the value before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; the upper bits select the page |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when no read is in progress |
| dout_vld | output | 1 | High while `dout` carries array data |
| busy_n | output | 1 | Low during the programming phase |

## Verification
Two events can coincide: the load timer running out, and the start of a new write pulse. The one that wins decides whether the new byte joins the open page or lands in the busy window and is dropped. Both strobe edges pass through the same filter latency, so the gap the bench sets between pulses is the gap the timer sees. The bench places a second byte well inside the timeout and another well after the page has closed. It then judges the outcome by the count of programming phases and by reading back both locations.

// File: rtl/pwl_pkg.sv
// Shared types for the page write load controller.
package pwl_pkg;
    // Controller phases: no page open, page loading, array programming.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pwl_state_e;
endpackage

// File: rtl/pwl_strobe_filt.sv
// Strobe synchroniser with glitch filter.
// Brings one asynchronous strobe into the clock domain through two flops.
// The clean output changes only after the synchronised level has differed
// from it for FILT_CYC consecutive clocks. Assumes FILT_CYC >= 2.
module pwl_strobe_filt #(
    parameter int   FILT_CYC = 3,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] run;

    // Synchronise, then accept a new level only once it has persisted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1    <= RST_VAL;
            s2    <= RST_VAL;
            clean <= RST_VAL;
            run   <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 == clean) begin
                run <= '0;
            end else if (run == CW'(FILT_CYC - 1)) begin
                clean <= s2;
                run   <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    // R10: a change of the clean level always follows the synchronised input.
    p_filter_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |-> (clean == $past(s2)));
endmodule

// File: rtl/pwl_ctrl.sv
// Load timer and programming sequencer.
// Turns the filtered write condition into address-capture and data-latch
// pulses, closes the page after LOAD_CYC idle clocks, and then holds the
// programming phase for WC_CYC clocks. Pulses that begin while programming
// is under way are not accepted. Assumes LOAD_CYC >= 1 and WC_CYC >= 1.
module pwl_ctrl
    import pwl_pkg::*;
#(
    parameter int LOAD_CYC = 12500,
    parameter int WC_CYC   = 375000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    output logic cap_addr,
    output logic latch,
    output logic commit,
    output logic busy_n
);
    localparam int MAXC = (LOAD_CYC > WC_CYC) ? LOAD_CYC : WC_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    pwl_state_e    state;
    logic [CW-1:0] cnt;
    logic          wr_q, acc, rise, fall;

    assign rise     = wr_act && !wr_q;
    assign fall     = !wr_act && wr_q;
    assign cap_addr = rise && (state != ST_PROG);
    assign latch    = fall && acc;
    assign commit   = (state == ST_PROG) && (cnt == '0);
    assign busy_n   = (state != ST_PROG);

    // Remember the previous write condition and whether this pulse was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            acc  <= 1'b0;
        end else begin
            wr_q <= wr_act;
            if (rise)      acc <= (state != ST_PROG);
            else if (fall) acc <= 1'b0;
        end
    end

    // Phase sequencing with a shared down-counter for load timeout and programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (latch) begin
                        state <= ST_LOAD;
                        cnt   <= CW'(LOAD_CYC - 1);
                    end
                end
                ST_LOAD: begin
                    if (wr_act || latch) begin
                        cnt <= CW'(LOAD_CYC - 1);
                    end else if (cnt == '0) begin
                        state <= ST_PROG;
                        cnt   <= CW'(WC_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PROG: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: no byte can be latched while programming is under way.
    p_no_latch_in_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |-> !latch);
    // R6: busy is released right after the commit.
    p_release_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy_n);
    // R6: busy stays low until the commit cycle.
    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && !commit) |=> !busy_n);
    // R4: busy can only begin from an open page with no pulse in progress.
    p_busy_from_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> ($past(state) == ST_LOAD && !$past(wr_act)));
endmodule

// File: rtl/pwl_page_buf.sv
// Page buffer.
// Holds one byte slot and one loaded flag per page offset, the page tag of
// the first byte, and a sticky flag set when a later byte names another
// page. The address comes from the pulse start and the data from its end.
module pwl_page_buf #(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cap_addr,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              latch,
    input  logic [DATA_W-1:0]                 din,
    input  logic                              clear,
    output logic [(1<<BYTE_W)*DATA_W-1:0]     page_data,
    output logic [(1<<BYTE_W)-1:0]            page_vld,
    output logic [ADDR_W-BYTE_W-1:0]          page_tag,
    output logic                              mismatch
);
    localparam int PAGE_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] a_hold;
    logic              have_tag;
    logic [BYTE_W-1:0] a_byte;
    logic [PAGE_W-1:0] a_page;

    assign a_byte = a_hold[BYTE_W-1:0];
    assign a_page = a_hold[ADDR_W-1:BYTE_W];

    // Keep the address seen when the write condition began.
    always_ff @(posedge clk) begin
        if (!rst_n)        a_hold <= '0;
        else if (cap_addr) a_hold <= addr;
    end

    // Store latched bytes, track the page tag and any page disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_data <= '0;
            page_vld  <= '0;
            page_tag  <= '0;
            have_tag  <= 1'b0;
            mismatch  <= 1'b0;
        end else if (clear) begin
            page_vld <= '0;
            have_tag <= 1'b0;
            mismatch <= 1'b0;
        end else if (latch) begin
            page_data[a_byte*DATA_W +: DATA_W] <= din;
            page_vld[a_byte]                   <= 1'b1;
            if (!have_tag) begin
                page_tag <= a_page;
                have_tag <= 1'b1;
            end else if (a_page != page_tag) begin
                mismatch <= 1'b1;
            end
        end
    end

    // R3: a commit leaves the buffer empty for the next page.
    p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (page_vld == '0 && !mismatch));
    // R5: a page disagreement persists until the page is retired.
    p_mismatch_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !clear) |=> mismatch);
endmodule

// File: rtl/pwl_array.sv
// Register storage array.
// Resets to all ones. On a commit it copies every flagged byte of the
// buffered page into the addressed page and leaves the other bytes alone.
// The read port is registered and returns zero when no read is active.
module pwl_array #(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-BYTE_W-1:0]          wr_page,
    input  logic [(1<<BYTE_W)*DATA_W-1:0]     wr_data,
    input  logic [(1<<BYTE_W)-1:0]            wr_mask,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              rd_vld
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Erase on reset, then merge committed bytes of one page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (wr_mask[j])
                    mem[{wr_page, BYTE_W'(j)}] <= wr_data[j*DATA_W +: DATA_W];
            end
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_data <= rd_en ? mem[rd_addr] : '0;
            rd_vld  <= rd_en;
        end
    end
endmodule

// File: rtl/pwl_ctrl_top.sv
// Page write load controller, top level.
// Filters the three bus strobes, decodes the write and read conditions,
// and connects the sequencer, the page buffer and the storage array.
// Assumes addr and din are held steady while the filtered strobes settle.
module pwl_ctrl_top #(
    parameter int ADDR_W   = 11,
    parameter int BYTE_W   = 6,
    parameter int DATA_W   = 8,
    parameter int FILT_CYC = 3,
    parameter int LOAD_CYC = 12500,
    parameter int WC_CYC   = 375000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              busy_n
);
    localparam int PAGE_W     = ADDR_W - BYTE_W;
    localparam int PAGE_BYTES = 1 << BYTE_W;
    localparam int N_STRB     = 3;

    logic [N_STRB-1:0] strb_raw, strb_f;
    logic ce_f, we_f, oe_f, wr_act, rd_act;
    logic cap_addr, latch, commit, mismatch;
    logic [PAGE_BYTES*DATA_W-1:0] page_data;
    logic [PAGE_BYTES-1:0]        page_vld;
    logic [PAGE_W-1:0]            page_tag;

    assign strb_raw = {oe_n, we_n, ce_n};

    // One filter per strobe.
    for (genvar g = 0; g < N_STRB; g++) begin : g_filt
        pwl_strobe_filt #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (strb_raw[g]),
            .clean (strb_f[g])
        );
    end

    assign ce_f   = strb_f[0];
    assign we_f   = strb_f[1];
    assign oe_f   = strb_f[2];
    assign wr_act = !ce_f && !we_f && oe_f;
    assign rd_act = !ce_f && !oe_f && we_f;

    pwl_ctrl #(.LOAD_CYC(LOAD_CYC), .WC_CYC(WC_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_act   (wr_act),
        .cap_addr (cap_addr),
        .latch    (latch),
        .commit   (commit),
        .busy_n   (busy_n)
    );

    pwl_page_buf #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_addr  (cap_addr),
        .addr      (addr),
        .latch     (latch),
        .din       (din),
        .clear     (commit),
        .page_data (page_data),
        .page_vld  (page_vld),
        .page_tag  (page_tag),
        .mismatch  (mismatch)
    );

    pwl_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit && !mismatch),
        .wr_page (page_tag),
        .wr_data (page_data),
        .wr_mask (page_vld),
        .rd_en   (rd_act),
        .rd_addr (addr),
        .rd_data (dout),
        .rd_vld  (dout_vld)
    );

    // R1: a latched byte is always preceded by an accepted write condition.
    p_latch_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> $past(wr_act));
    // R11: read data is flagged only after a read condition.
    p_read_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> $past(rd_act));
endmodule

// File: tb/pwl_ctrl_top_tb.sv
module pwl_ctrl_top_tb;
    localparam int AW = 11, DW = 8, LOAD = 40, WC = 100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_vld, busy_n;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwl_ctrl_top #(.ADDR_W(AW), .BYTE_W(6), .DATA_W(DW), .FILT_CYC(3),
                   .LOAD_CYC(LOAD), .WC_CYC(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld), .busy_n(busy_n));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(8);
        ce_n = 1'b1; we_n = 1'b1;
        idle(8);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        idle(8);
        d = dout; v = dout_vld;
        ce_n = 1'b1; oe_n = 1'b1;
        idle(8);
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] e);
        logic [DW-1:0] d; logic v;
        bus_read(a, d, v);
        chk(req, int'(v), 1);
        chk(req, int'(d), int'(e));
    endtask

    // Waits up to lim cycles for busy to fall; returns cycles waited or -1.
    task automatic wait_fall(input int lim, output int n);
        n = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (!busy_n) begin n = i; break; end
        end
    endtask

    // Counts low cycles of busy until it rises.
    task automatic busy_len(output int n);
        n = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (busy_n) break;
            n++;
        end
    endtask

    task automatic commit_len(input string req);
        int w, n;
        wait_fall(300, w);
        chk({req, " busy fell"}, int'(w >= 0), 1);
        busy_len(n);
        chk("R6 busy length", n, WC);
    endtask

    task automatic t_reset;
        idle(1);
        chk("R7 busy_n after reset", int'(busy_n), 1);
        chk("R11 no read flag idle", int'(dout_vld), 0);
        rd_chk("R7 erased low", 11'h000, 8'hFF);
        rd_chk("R7 erased high", 11'h7FF, 8'hFF);
    endtask

    task automatic t_single;
        bus_write(11'h123, 8'h5A);
        commit_len("R4");
        rd_chk("R11 single byte", 11'h123, 8'h5A);
    endtask

    task automatic t_page;
        int w;
        bus_write(11'h080, 8'h11);
        bus_write(11'h081, 8'h22);
        bus_write(11'h0BF, 8'h33);
        commit_len("R3");
        wait_fall(200, w);
        chk("R6 no second phase", w, -1);
        rd_chk("R3 page byte 0", 11'h080, 8'h11);
        rd_chk("R3 page byte 1", 11'h081, 8'h22);
        rd_chk("R3 page byte 63", 11'h0BF, 8'h33);
        rd_chk("R9 unloaded byte", 11'h082, 8'hFF);
    endtask

    task automatic t_timeout;
        int w;
        bus_write(11'h400, 8'h44);
        idle(12);
        chk("R4 still loading", int'(busy_n), 1);
        wait_fall(100, w);
        chk("R4 timeout window", int'(w >= 0 && w < 40), 1);
        busy_len(w);
        rd_chk("R4 committed", 11'h400, 8'h44);
    endtask

    task automatic t_mismatch;
        bus_write(11'h100, 8'hAA);
        bus_write(11'h140, 8'hBB);
        commit_len("R5");
        rd_chk("R5 first discarded", 11'h100, 8'hFF);
        rd_chk("R5 second discarded", 11'h140, 8'hFF);
    endtask

    task automatic t_busy_ignore;
        int w, n;
        bus_write(11'h200, 8'h01);
        wait_fall(300, w);
        bus_write(11'h201, 8'h02);
        busy_len(n);
        wait_fall(200, w);
        chk("R8 no extra phase", w, -1);
        rd_chk("R8 first kept", 11'h200, 8'h01);
        rd_chk("R8 busy write ignored", 11'h201, 8'hFF);
    endtask

    task automatic t_strobes;
        int w;
        @(negedge clk);
        addr = 11'h300; din = 8'h99; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        idle(8);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(4);
        we_n = 1'b0;
        idle(8);
        we_n = 1'b1;
        wait_fall(150, w);
        chk("R1 no write recognised", w, -1);
        rd_chk("R1 location untouched", 11'h300, 8'hFF);
    endtask

    task automatic t_glitch;
        int w;
        @(negedge clk);
        addr = 11'h310; din = 8'h77; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        ce_n = 1'b1; we_n = 1'b1;
        wait_fall(150, w);
        chk("R10 glitch ignored", w, -1);
        rd_chk("R10 location untouched", 11'h310, 8'hFF);
    endtask

    task automatic t_capture;
        @(negedge clk);
        addr = 11'h320; din = 8'h11; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(7);
        addr = 11'h325; din = 8'h7E;
        idle(6);
        ce_n = 1'b1; we_n = 1'b1;
        idle(8);
        commit_len("R2");
        rd_chk("R2 start address, end data", 11'h320, 8'h7E);
        rd_chk("R2 late address unused", 11'h325, 8'hFF);
    endtask

    task automatic t_read_during_busy;
        int w, n;
        bus_write(11'h123, 8'hA5);
        wait_fall(300, w);
        rd_chk("R11 old data while busy", 11'h123, 8'h5A);
        busy_len(n);
        rd_chk("R11 new data after commit", 11'h123, 8'hA5);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_page();
        t_timeout();
        t_mismatch();
        t_busy_ignore();
        t_strobes();
        t_glitch();
        t_capture();
        t_read_during_busy();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule